// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block merges a bank of 32 level-sensitive interrupt lines into one request line for a parent interrupt controller. Every line has its own bit in an internal mask. A line counts as pending while its input is high and its mask bit is set. The combined request is high whenever at least one line is pending. Nothing is latched, so a line stops being pending as soon as its input falls.

Software works through a small 32-bit register port. It reads the pending bits to see which sources need service. It opens sources with a write-one-to-set port and closes them with a write-one-to-clear port. A separate command location shuts every source in one write. No register holds the mask for direct read or write, so a write never has to read the mask and modify it.

Top module: `irqagg_top`

## Requirements
- R1: After reset every mask bit is 0, `irq_o` is low, and the pending register reads 0 even if all sources are high.
- R2: Reading byte offset 0x04 returns the pending word, whose bit n is source n AND mask bit n, sampled at the previous rising clock edge.
- R3: Sources are levels: a pending bit clears at the first clock edge after its source input falls, and nothing is remembered afterwards.
- R4: A write to offset 0x10 sets each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R5: A write to offset 0x0C clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R6: Any write to offset 0x08, whatever the data, clears all 32 mask bits.
- R7: `irq_o` is high exactly when at least one pending bit is 1. It falls in the cycle after the last enabled source drops or is masked.
- R8: Read data is 0 for offsets 0x08, 0x0C, 0x10 and any unmapped offset, and it is 0 whenever `rd_en_i` is low.
- R9: Writes to offset 0x04 and to unmapped offsets change no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt source lines, bit n is source n |
| addr_i | input | 8 | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as `rd_en_i` |
| irq_o | output | 1 | Combined interrupt request to the parent |

## Verification
The bench writes alternating and sparse patterns to the set and clear ports to confirm that 0 bits leave the mask untouched. A design that treated either port as a plain mask load would wipe out the bits that were not named. It writes zero data to the mask-all location to catch a design that uses the data instead of the write itself. It drops sources one cycle at a time and samples both before and after the clock edge. This catches a pending register that latches its bits, and an output that moves without the clock. Finally it writes to the pending offset and to an unmapped offset with all sources raised. Any leak into the mask then shows up as a change in the pending read.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int unsigned N_SRC    = 32;
    localparam int unsigned OFS_W    = 8;
    localparam logic [OFS_W-1:0] OFS_PEND   = 8'h04;
    localparam logic [OFS_W-1:0] OFS_MSKALL = 8'h08;
    localparam logic [OFS_W-1:0] OFS_CLR    = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_SET    = 8'h10;

    typedef logic [N_SRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t mask;
    } mask_st_t;

    typedef struct packed {
        src_vec_t pend;
    } pend_st_t;
endpackage

// File: rtl/irqagg_regdec.sv
module irqagg_regdec
    import irqagg_pkg::*;
(
    input  logic [OFS_W-1:0] addr_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  src_vec_t         wdata_i,
    input  src_vec_t         pend_i,
    output src_vec_t         set_o,
    output src_vec_t         clr_o,
    output logic             clr_all_o,
    output src_vec_t         rdata_o
);
    logic hit_set, hit_clr, hit_all, hit_pend;

    always_comb begin
        hit_pend  = (addr_i == OFS_PEND);
        hit_all   = (addr_i == OFS_MSKALL);
        hit_clr   = (addr_i == OFS_CLR);
        hit_set   = (addr_i == OFS_SET);
        set_o     = (wr_en_i && hit_set) ? wdata_i : '0;
        clr_o     = (wr_en_i && hit_clr) ? wdata_i : '0;
        clr_all_o = wr_en_i && hit_all;
        rdata_o   = (rd_en_i && hit_pend) ? pend_i : '0;
    end
endmodule

// File: rtl/irqagg_mask.sv
module irqagg_mask
    import irqagg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_i,
    input  src_vec_t clr_i,
    input  logic     clr_all_i,
    output src_vec_t mask_o
);
    mask_st_t st_d, st_q;

    // Clear dominates set on any bit named by both.
    always_comb begin
        st_d = st_q;
        if (clr_all_i) begin
            st_d.mask = '0;
        end else begin
            st_d.mask = (st_q.mask | set_i) & ~clr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    // R4: bits written as 1 to the set port are enabled afterwards
    a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all_i) |=> ((mask_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
    // R5: bits written as 1 to the clear port are disabled afterwards
    a_r5_clr_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((mask_o & $past(clr_i)) == '0));
    // R4 R5: untouched bits hold their value
    a_r5_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all_i) |=> (((mask_o ^ $past(mask_o)) & ~$past(set_i | clr_i)) == '0));
    // R6: mask-all empties the mask
    a_r6_all_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (mask_o == '0));
endmodule

// File: rtl/irqagg_pending.sv
module irqagg_pending
    import irqagg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t src_i,
    input  src_vec_t mask_i,
    output src_vec_t pend_o,
    output logic     irq_o
);
    pend_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = src_i & mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign irq_o  = |st_q.pend;

    // R3: a source that was low cannot be pending next cycle
    a_r3_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(src_i)) == '0));
    // R2: a masked source cannot be pending next cycle
    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(mask_i)) == '0));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [OFS_W-1:0]  addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [N_SRC-1:0]  wdata_i,
    output logic [N_SRC-1:0]  rdata_o,
    output logic              irq_o
);
    src_vec_t set_v, clr_v, mask_v, pend_v;
    logic     clr_all;

    irqagg_regdec u_dec (
        .addr_i   (addr_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .wdata_i  (wdata_i),
        .pend_i   (pend_v),
        .set_o    (set_v),
        .clr_o    (clr_v),
        .clr_all_o(clr_all),
        .rdata_o  (rdata_o)
    );

    irqagg_mask u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_v),
        .clr_i    (clr_v),
        .clr_all_i(clr_all),
        .mask_o   (mask_v)
    );

    irqagg_pending u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .mask_i(mask_v),
        .pend_o(pend_v),
        .irq_o (irq_o)
    );

    // R7: nothing enabled and active means no request next cycle
    a_r7_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i & mask_v) == '0) |=> !irq_o);
    // R8: only the pending offset returns data
    a_r8_quiet_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_i || addr_i != OFS_PEND) |-> (rdata_o == '0));
    // R9: writes off the mask ports leave the mask alone
    a_r9_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i != OFS_SET && addr_i != OFS_CLR && addr_i != OFS_MSKALL)
        |=> $stable(mask_v));
endmodule

// File: tb/irqagg_top_bench.sv
module irqagg_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    irqagg_top u_irqagg_top (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0; addr = '0;
    endtask

    // mask is updated after wr; one more edge lets pending follow
    task automatic mask_read(output logic [31:0] d);
        logic [31:0] s;
        s = src;
        @(negedge clk); src = '1;
        @(negedge clk);
        rd(8'h04, d);
        src = s;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        src = '1;
        @(negedge clk); @(negedge clk);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        rd(8'h04, d);
        check("R1 pending after reset", d, 32'd0);
        src = '0;
    endtask

    task automatic t_set;
        logic [31:0] d;
        wr(8'h10, 32'hA5A5_0000);
        wr(8'h10, 32'h0000_0003);
        mask_read(d);
        check("R4 set accumulates", d, 32'hA5A5_0003);
        wr(8'h10, 32'h0);
        mask_read(d);
        check("R4 zero data keeps mask", d, 32'hA5A5_0003);
    endtask

    task automatic t_clr;
        logic [31:0] d;
        wr(8'h0C, 32'h8001_0001);
        mask_read(d);
        check("R5 clear named bits", d, 32'h25A4_0002);
        wr(8'h0C, 32'h0);
        mask_read(d);
        check("R5 zero data keeps mask", d, 32'h25A4_0002);
    endtask

    task automatic t_all;
        logic [31:0] d;
        wr(8'h08, 32'h0);
        mask_read(d);
        check("R6 mask-all with zero data", d, 32'h0);
    endtask

    task automatic t_pend_level;
        logic [31:0] d;
        wr(8'h10, 32'hF0F0_F0F0);
        @(negedge clk); src = 32'h1234_5678;
        @(negedge clk);
        rd(8'h04, d);
        check("R2 pending is src and mask", d, 32'h1030_5070);
        check("R7 irq high", {31'd0, irq}, 32'd1);
        src = 32'h0000_0008;
        #1 check("R7 irq waits for edge", {31'd0, irq}, 32'd1);
        @(negedge clk);
        rd(8'h04, d);
        check("R3 no latch after drop", d, 32'h0);
        check("R7 irq falls", {31'd0, irq}, 32'd0);
        src = 32'h8000_0000;
        @(negedge clk);
        check("R7 irq rises", {31'd0, irq}, 32'd1);
        wr(8'h0C, 32'h8000_0000);
        @(negedge clk);
        check("R7 irq falls after mask", {31'd0, irq}, 32'd0);
        src = '0;
    endtask

    task automatic t_reads;
        logic [31:0] d;
        src = '1;
        @(negedge clk); @(negedge clk);
        rd(8'h08, d); check("R8 read 0x08", d, 32'h0);
        rd(8'h0C, d); check("R8 read 0x0C", d, 32'h0);
        rd(8'h10, d); check("R8 read 0x10", d, 32'h0);
        rd(8'h44, d); check("R8 read unmapped", d, 32'h0);
        addr = 8'h04;
        #1 check("R8 no rd_en", rdata, 32'h0);
        src = '0;
    endtask

    task automatic t_stray;
        logic [31:0] d;
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        mask_read(d);
        check("R9 stray writes ignored", d, 32'h70F0_F0F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set();
        t_clr();
        t_all();
        t_pend_level();
        t_reads();
        t_stray();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule